// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator with Per-Field Masks

This block watches the current calendar time (day of month, hours, minutes, seconds) and compares it against four programmed alarm fields. Each field has its own select bit that either includes the field in the comparison or removes it. With only seconds included, the alarm repeats once a minute. Adding minutes makes it hourly, adding hours makes it daily, and adding the day of month makes it monthly. When every select bit removes its field, the alarm is switched off.

The comparison is evaluated only on the seconds-update strobe from the timekeeping counters. A hit sets a sticky alarm flag. Software clears the flag when it reads the flags register, which this block sees as a one-cycle read strobe. The interrupt line follows the flag, gated by the interrupt enable. The timekeeping counters and the bus decode sit outside this block.

Top module: `rtc_alarm_match`

## Requirements
- R1: After reset, alarmFlag and irqOut are 0.
- R2: almSel bit 0 selects seconds, bit 1 minutes, bit 2 hours and bit 3 day of month. A bit value of 0 includes the field and 1 excludes it. A match requires every included field to equal its current-time field over all 8 bits of the BCD code.
- R3: When almSel is 4'b1111, alarmFlag is never set, even when all fields are equal.
- R4: When almSel is 4'b0000, a match requires the day, hours, minutes and seconds to be equal. A difference in any one of them prevents the match.
- R5: On a rising clock edge where secTick is 1 and the included fields match, alarmFlag becomes 1. It stays 1 until it is cleared.
- R6: A flagRead pulse clears alarmFlag at the next edge. If a set condition occurs in the same cycle as the read, the set wins.
- R7: alarmFlag is never set in a cycle without secTick. A match that persists for one second therefore sets the flag only once, and a read within that second leaves the flag cleared.
- R8: irqOut equals alarmFlag AND irqEn at all times.
- R9: Including only seconds gives a once-per-minute alarm: the flag is set when the seconds are equal, whatever the other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| secTick | input | 1 | One-cycle strobe when the seconds value updates |
| curDate | input | 8 | Current day of month, BCD |
| curHour | input | 8 | Current hours, BCD |
| curMin | input | 8 | Current minutes, BCD |
| curSec | input | 8 | Current seconds, BCD |
| almDate | input | 8 | Alarm day of month, BCD |
| almHour | input | 8 | Alarm hours, BCD |
| almMin | input | 8 | Alarm minutes, BCD |
| almSec | input | 8 | Alarm seconds, BCD |
| almSel | input | 4 | Per-field select; 0 includes the field |
| irqEn | input | 1 | Alarm interrupt enable |
| flagRead | input | 1 | One-cycle strobe for a flags-register read |
| alarmFlag | output | 1 | Sticky alarm flag |
| irqOut | output | 1 | Alarm interrupt, active high |

## Verification
The assertions assume three things:
- secTick and flagRead are synchronous to clk.
- The time and alarm fields are stable throughout any cycle in which secTick is high.
- almSel does not change between the tick and the edge that samples it.

The bench drives every input only at the falling edge. It changes the fields and almSel only while secTick is low, and it raises secTick for exactly one cycle at a time. Under these conditions the properties that relate a tick and a match to the flag on the next edge are valid.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  // strobes sent from control to datapath
  typedef struct packed {
    logic setFlag;
    logic clrFlag;
  } flagStrobe_t;
endpackage

// File: rtl/alarm_dp.sv
module alarm_dp
  import rtc_alarm_pkg::*;
#(
  parameter int N_FIELDS = 4,
  parameter int FIELD_W  = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0]  curT,
  input  logic [N_FIELDS-1:0][FIELD_W-1:0]  almT,
  input  logic [N_FIELDS-1:0]               sel,
  input  flagStrobe_t                       st,
  output logic                              hit,
  output logic                              flagQ
);
  logic [N_FIELDS-1:0] fieldOk;

  // a field passes when excluded or equal
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    assign fieldOk[i] = sel[i] | (curT[i] == almT[i]);
  end

  // all-excluded means alarm disabled
  assign hit = (&fieldOk) & ~(&sel);

  always_ff @(posedge clk) begin
    if (!rstN)            flagQ <= 1'b0;
    else if (st.setFlag)  flagQ <= 1'b1;
    else if (st.clrFlag)  flagQ <= 1'b0;
  end

  always @(posedge clk) begin
    if (rstN) AST_STROBE_EXCL: assert (!(st.setFlag && st.clrFlag)); // R6
  end
endmodule

// File: rtl/alarm_ctrl.sv
module alarm_ctrl
  import rtc_alarm_pkg::*;
(
  input  logic        secTick,
  input  logic        hit,
  input  logic        flagRead,
  output flagStrobe_t st
);
  always_comb begin
    st.setFlag = secTick & hit;
    // a set in the same cycle takes priority over the read clear
    st.clrFlag = flagRead & ~st.setFlag;
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter int FIELD_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               secTick,
  input  logic [FIELD_W-1:0] curDate,
  input  logic [FIELD_W-1:0] curHour,
  input  logic [FIELD_W-1:0] curMin,
  input  logic [FIELD_W-1:0] curSec,
  input  logic [FIELD_W-1:0] almDate,
  input  logic [FIELD_W-1:0] almHour,
  input  logic [FIELD_W-1:0] almMin,
  input  logic [FIELD_W-1:0] almSec,
  input  logic [3:0]         almSel,
  input  logic               irqEn,
  input  logic               flagRead,
  output logic               alarmFlag,
  output logic               irqOut
);
  localparam int N_FIELDS = 4;

  logic [N_FIELDS-1:0][FIELD_W-1:0] curT, almT;
  flagStrobe_t st;
  logic        hit;

  // index order: 0 seconds, 1 minutes, 2 hours, 3 day of month
  assign curT = {curDate, curHour, curMin, curSec};
  assign almT = {almDate, almHour, almMin, almSec};

  alarm_ctrl u_ctrl (
    .secTick (secTick),
    .hit     (hit),
    .flagRead(flagRead),
    .st      (st)
  );

  alarm_dp #(.N_FIELDS(N_FIELDS), .FIELD_W(FIELD_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .curT (curT),
    .almT (almT),
    .sel  (almSel),
    .st   (st),
    .hit  (hit),
    .flagQ(alarmFlag)
  );

  assign irqOut = alarmFlag & irqEn;

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (almSel == 4'hF && !alarmFlag) |=> !alarmFlag); // R3
  AST_NO_TICK_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!secTick && !alarmFlag) |=> !alarmFlag); // R7
  AST_EXACT_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (secTick && almSel == 4'h0 && curDate == almDate && curHour == almHour
     && curMin == almMin && curSec == almSec) |=> alarmFlag); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !secTick) |=> !alarmFlag); // R6
  AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (alarmFlag && !flagRead) |=> alarmFlag); // R5
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut); // R8
endmodule

// File: tb/sim_rtc_alarm_match.sv
module sim_rtc_alarm_match;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN, secTick, irqEn, flagRead;
  logic [7:0] curDate, curHour, curMin, curSec;
  logic [7:0] almDate, almHour, almMin, almSec;
  logic [3:0] almSel;
  logic alarmFlag, irqOut;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_alarm_match u0 (.*);

  // {cur day,hour,min,sec ; alarm day,hour,min,sec ; select ; expected flag}
  localparam logic [68:0] VEC [0:8] = '{
    {32'h15_10_30_45, 32'h15_10_30_45, 4'b0000, 1'b1},  // R4 exact
    {32'h16_10_30_45, 32'h15_10_30_45, 4'b0000, 1'b0},  // R4 day differs
    {32'h16_10_30_45, 32'h15_10_30_45, 4'b1000, 1'b1},  // R2 day excluded
    {32'h03_22_07_59, 32'h28_11_41_59, 4'b1110, 1'b1},  // R9 seconds only
    {32'h03_22_07_58, 32'h28_11_41_59, 4'b1110, 1'b0},  // R9 seconds differ
    {32'h09_05_12_00, 32'h21_23_12_00, 4'b1100, 1'b1},  // R2 hourly
    {32'h31_23_58_30, 32'h31_23_00_30, 4'b0010, 1'b1},  // R2 minutes excluded
    {32'h15_10_30_45, 32'h15_10_30_45, 4'b1111, 1'b0},  // R3 disabled
    {32'h15_10_30_45, 32'h15_11_30_45, 4'b1011, 1'b0}   // R2 hours only, differ
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic setFields(input logic [68:0] v);
    {curDate, curHour, curMin, curSec} = v[68:37];
    {almDate, almHour, almMin, almSec} = v[36:5];
    almSel = v[4:1];
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    rstN = 0; secTick = 0; irqEn = 1; flagRead = 0;
    setFields(VEC[0]);
    cyc(); cyc();
    check("R1 flag after reset", alarmFlag, 1'b0);
    check("R1 irq after reset", irqOut, 1'b0);
    rstN = 1;

    for (int i = 0; i < 9; i++) begin
      flagRead = 1; setFields(VEC[i]);
      cyc();
      flagRead = 0; secTick = 1;
      cyc();
      secTick = 0;
      check($sformatf("R2 vector %0d flag", i), alarmFlag, VEC[i][0]);
      check($sformatf("R8 vector %0d irq", i), irqOut, VEC[i][0]);
    end

    // R7: match present but no tick -> no set
    flagRead = 1; setFields(VEC[0]);
    cyc(); flagRead = 0;
    cyc(); cyc(); cyc();
    check("R7 no tick no set", alarmFlag, 1'b0);

    // R5: set and sticky
    secTick = 1; cyc(); secTick = 0;
    check("R5 set on tick", alarmFlag, 1'b1);
    cyc(); cyc(); setFields(VEC[1]); cyc();
    check("R5 sticky after mismatch", alarmFlag, 1'b1);

    // R8: enable gating
    irqEn = 0; #1;
    check("R8 irq masked", irqOut, 1'b0);
    irqEn = 1; #1;
    check("R8 irq follows flag", irqOut, 1'b1);

    // R6: read clears; within same second no re-set (R7)
    setFields(VEC[0]);
    flagRead = 1; cyc(); flagRead = 0;
    check("R6 read clears", alarmFlag, 1'b0);
    check("R6 irq drops with flag", irqOut, 1'b0);
    cyc(); cyc();
    check("R7 no re-set in same second", alarmFlag, 1'b0);

    // R6: set wins over simultaneous read
    secTick = 1; flagRead = 1; cyc(); secTick = 0; flagRead = 0;
    check("R6 set wins over read", alarmFlag, 1'b1);

    // R3: disabled with all fields equal, tick present
    flagRead = 1; setFields(VEC[7]); cyc(); flagRead = 0;
    secTick = 1; cyc(); secTick = 0; cyc();
    check("R3 all-excluded never sets", alarmFlag, 1'b0);

    // R1: reset clears a set flag
    setFields(VEC[0]); secTick = 1; cyc(); secTick = 0;
    rstN = 0; cyc(); rstN = 1;
    check("R1 reset clears flag", alarmFlag, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule